// File: doc/BRIEF.md
# Instruction Decode Stage with Load-Use Hazard Flag

This block sits between instruction fetch and execute in a pipelined 32-bit core. From the incoming instruction word it extracts two register indices and drives them straight to the register file, without a clock edge in between. On the clock edge where it is enabled, it captures the instruction into its decoded-instruction register. In the following cycle the register file returns the two operand words, and the stage presents them as the base operand and the second operand.

Two corrections are applied on the way through. A program-counter read, index 15, on the second port is increased by 4. The same index on the first port passes through unchanged. The stage also raises a load-use flag when the instruction it captures reads a register that the load captured just before it writes.

A two-state controller sets the timing. In IDLE, ready is low and every output holds its value. In RUN, ready is high and the operand outputs follow the register file. The transition START goes from IDLE to RUN and is taken on an edge where enable is high. The transition PAUSE goes from RUN to IDLE and is taken on an edge where enable is low. Both states loop on themselves otherwise.

Top module: `decode_stage`

## Requirements
- R1: While rst_n is low, ready, load_use_stall, dec_instr, opnd_n and opnd_m are all zero after the next clock edge.
- R2: rf_raddr_a always equals fetch_instr[19:16] in the same cycle, without a clock edge.
- R3: rf_raddr_b equals fetch_instr[3:0] in the same cycle, except for stores. A store has fetch_instr[27:26]=01 and fetch_instr[20]=0, and for it rf_raddr_b is fetch_instr[15:12].
- R4: ready is high in exactly the cycles that follow a clock edge at which enable was high.
- R5: At an edge where enable is high, dec_instr takes the value of fetch_instr. At an edge where enable is low, dec_instr keeps its value.
- R6: While ready is high, opnd_n equals rf_rdata_a, including when the first index captured was 15.
- R7: While ready is high, opnd_m equals rf_rdata_b when the second index captured was not 15, and rf_rdata_b + 4 when it was 15.
- R8: While ready is low, opnd_n and opnd_m hold the values they had in the previous cycle, whatever rf_rdata_a and rf_rdata_b do.
- R9: At an edge where enable is high, load_use_stall is set if the previously captured instruction is a load and its destination matches either read index of the new instruction. A load has fetch_instr[27:26]=01 and fetch_instr[20]=1, and its destination is bits [15:12]. Otherwise load_use_stall is cleared at that edge.
- R10: At an edge where enable is low, load_use_stall keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Advance the stage at this edge |
| fetch_instr | input | 32 | Instruction word from fetch |
| rf_rdata_a | input | 32 | Register file data for index A |
| rf_rdata_b | input | 32 | Register file data for index B |
| rf_raddr_a | output | 4 | Register file read index A |
| rf_raddr_b | output | 4 | Register file read index B |
| dec_instr | output | 32 | Captured instruction |
| ready | output | 1 | Outputs valid for this cycle |
| load_use_stall | output | 1 | Load-use hazard detected |
| opnd_n | output | 32 | Base operand |
| opnd_m | output | 32 | Second operand, PC-corrected |

## Verification
Two things can happen on the same edge. The stage can capture a new instruction and set the hazard flag from the load captured before it. On the same edge it can also move the old operand values into the hold register, which happens when enable is dropped next. The bench provokes both on purpose. A directed load is followed by a dependent instruction, and then enable is dropped while the register file data changes. Random runs use a small pool of indices that includes 15, so that these coincidences happen often. Each cycle, the expected ready, captured word, stall flag, read indices and operands are computed from the requirements alone and compared with the outputs.

// File: rtl/decode_stage_pkg.sv
package decode_stage_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } dstate_t;

    localparam logic [1:0] CLS_MEM = 2'b01;
endpackage

// File: rtl/ds_field_sel.sv
module ds_field_sel #(
    parameter int XW = 32,
    parameter int RW = 4
) (
    input  logic [XW-1:0] instr,
    output logic [RW-1:0] addr_a,
    output logic [RW-1:0] addr_b,
    output logic          is_load,
    output logic [RW-1:0] dst
);
    import decode_stage_pkg::*;

    logic is_mem;

    always_comb begin
        is_mem  = (instr[27:26] == CLS_MEM);
        is_load = is_mem && instr[20];
        dst     = instr[15:12];
        addr_a  = instr[19:16];
        // stores fetch their data register through port B
        addr_b  = (is_mem && !instr[20]) ? instr[15:12] : instr[3:0];
    end
endmodule

// File: rtl/ds_hazard.sv
module ds_hazard #(
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic          new_is_load,
    input  logic [RW-1:0] new_dst,
    input  logic [RW-1:0] new_a,
    input  logic [RW-1:0] new_b,
    output logic          stall
);
    logic          prev_load;
    logic [RW-1:0] prev_dst;
    logic          hit;

    always_comb begin
        hit = prev_load && ((prev_dst == new_a) || (prev_dst == new_b));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_load <= 1'b0;
            prev_dst  <= '0;
            stall     <= 1'b0;
        end else if (capture) begin
            prev_load <= new_is_load;
            prev_dst  <= new_dst;
            stall     <= hit;
        end
    end
endmodule

// File: rtl/ds_operand.sv
module ds_operand #(
    parameter int XW     = 32,
    parameter int PC_ADJ = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          live,
    input  logic          b_is_pc,
    input  logic [XW-1:0] rdata_a,
    input  logic [XW-1:0] rdata_b,
    output logic [XW-1:0] opnd_n,
    output logic [XW-1:0] opnd_m
);
    logic [XW-1:0] cur_n, cur_m;
    logic [XW-1:0] held_n, held_m;

    always_comb begin
        cur_n  = rdata_a;
        cur_m  = b_is_pc ? (rdata_b + XW'(PC_ADJ)) : rdata_b;
        opnd_n = live ? cur_n : held_n;
        opnd_m = live ? cur_m : held_m;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_n <= '0;
            held_m <= '0;
        end else if (live) begin
            held_n <= cur_n;
            held_m <= cur_m;
        end
    end
endmodule

// File: rtl/decode_stage.sv
module decode_stage #(
    parameter int XW     = 32,
    parameter int RW     = 4,
    parameter int PC_IDX = 15,
    parameter int PC_ADJ = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [XW-1:0] fetch_instr,
    input  logic [XW-1:0] rf_rdata_a,
    input  logic [XW-1:0] rf_rdata_b,
    output logic [RW-1:0] rf_raddr_a,
    output logic [RW-1:0] rf_raddr_b,
    output logic [XW-1:0] dec_instr,
    output logic          ready,
    output logic          load_use_stall,
    output logic [XW-1:0] opnd_n,
    output logic [XW-1:0] opnd_m
);
    import decode_stage_pkg::*;

    localparam logic [RW-1:0] PC_SEL = RW'(PC_IDX);

    dstate_t       state, state_nx;
    logic          new_is_load;
    logic [RW-1:0] new_dst;
    logic          b_pc_q;

    ds_field_sel #(.XW(XW), .RW(RW)) u_sel (
        .instr   (fetch_instr),
        .addr_a  (rf_raddr_a),
        .addr_b  (rf_raddr_b),
        .is_load (new_is_load),
        .dst     (new_dst)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions: START (IDLE->RUN), PAUSE (RUN->IDLE)
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: state_nx = enable ? ST_RUN  : ST_IDLE;
            ST_RUN:  state_nx = enable ? ST_RUN  : ST_IDLE;
        endcase
    end

    // outputs of the controller
    always_comb begin
        ready = (state == ST_RUN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dec_instr <= '0;
            b_pc_q    <= 1'b0;
        end else if (enable) begin
            dec_instr <= fetch_instr;
            b_pc_q    <= (rf_raddr_b == PC_SEL);
        end
    end

    ds_hazard #(.RW(RW)) u_haz (
        .clk         (clk),
        .rst_n       (rst_n),
        .capture     (enable),
        .new_is_load (new_is_load),
        .new_dst     (new_dst),
        .new_a       (rf_raddr_a),
        .new_b       (rf_raddr_b),
        .stall       (load_use_stall)
    );

    ds_operand #(.XW(XW), .PC_ADJ(PC_ADJ)) u_opnd (
        .clk     (clk),
        .rst_n   (rst_n),
        .live    (ready),
        .b_is_pc (b_pc_q),
        .rdata_a (rf_rdata_a),
        .rdata_b (rf_rdata_b),
        .opnd_n  (opnd_n),
        .opnd_m  (opnd_m)
    );
endmodule

// File: rtl/decode_stage_chk.sv
module decode_stage_chk #(
    parameter int XW = 32,
    parameter int RW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic [XW-1:0] fetch_instr,
    input logic [XW-1:0] rf_rdata_a,
    input logic [XW-1:0] rf_rdata_b,
    input logic [RW-1:0] rf_raddr_a,
    input logic [RW-1:0] rf_raddr_b,
    input logic [XW-1:0] dec_instr,
    input logic          ready,
    input logic          load_use_stall,
    input logic [XW-1:0] opnd_n,
    input logic [XW-1:0] opnd_m
);
    assert_ready_follows_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> $past(enable));

    assert_instr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> $stable(dec_instr));

    assert_base_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> opnd_n == rf_rdata_a);

    assert_pc_adjust_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && $past(rf_raddr_b) == 4'd15) |-> opnd_m == rf_rdata_b + 32'd4);

    assert_operand_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> ($stable(opnd_n) && $stable(opnd_m)));

    assert_stall_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(load_use_stall) |-> $past(enable));

    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(enable) |-> $stable(load_use_stall));

    assert_addr_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rf_raddr_a == fetch_instr[19:16]);
endmodule

bind decode_stage decode_stage_chk #(.XW(XW), .RW(RW)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .enable         (enable),
    .fetch_instr    (fetch_instr),
    .rf_rdata_a     (rf_rdata_a),
    .rf_rdata_b     (rf_rdata_b),
    .rf_raddr_a     (rf_raddr_a),
    .rf_raddr_b     (rf_raddr_b),
    .dec_instr      (dec_instr),
    .ready          (ready),
    .load_use_stall (load_use_stall),
    .opnd_n         (opnd_n),
    .opnd_m         (opnd_m)
);

// File: tb/decode_stage_test.sv
`timescale 1ns/1ps
module decode_stage_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [31:0] fetch_instr = '0;
    logic [31:0] rf_rdata_a = '0;
    logic [31:0] rf_rdata_b = '0;
    logic [3:0]  rf_raddr_a, rf_raddr_b;
    logic [31:0] dec_instr, opnd_n, opnd_m;
    logic        ready, load_use_stall;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // expected state
    bit          m_ready;
    logic [31:0] m_instr;
    bit          m_stall;
    bit          m_prev_ld;
    logic [3:0]  m_prev_dst;
    bit          m_bpc;
    logic [31:0] m_on, m_om;

    always #2 clk = ~clk;

    decode_stage uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fetch_instr(fetch_instr),
        .rf_rdata_a(rf_rdata_a), .rf_rdata_b(rf_rdata_b),
        .rf_raddr_a(rf_raddr_a), .rf_raddr_b(rf_raddr_b),
        .dec_instr(dec_instr), .ready(ready), .load_use_stall(load_use_stall),
        .opnd_n(opnd_n), .opnd_m(opnd_m)
    );

    function automatic logic [3:0] f_a(logic [31:0] i);
        return i[19:16];
    endfunction
    function automatic logic [3:0] f_b(logic [31:0] i);
        return (i[27:26] == 2'b01 && !i[20]) ? i[15:12] : i[3:0];
    endfunction
    function automatic bit f_ld(logic [31:0] i);
        return (i[27:26] == 2'b01) && i[20];
    endfunction
    // kind: 0 move/data, 1 load (register offset), 2 store
    function automatic logic [31:0] mk(int kind, logic [3:0] rn, logic [3:0] rd, logic [3:0] rm);
        logic [5:0] fl;
        logic [1:0] cl;
        case (kind)
            1:       begin cl = 2'b01; fl = 6'b111001; end
            2:       begin cl = 2'b01; fl = 6'b111000; end
            default: begin cl = 2'b00; fl = 6'b011010; end
        endcase
        return {4'hE, cl, fl, rn, rd, 8'h00, rm};
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one cycle: drive at negedge, check, then model the edge
    task automatic step(bit en, logic [31:0] ins, logic [31:0] da, logic [31:0] db);
        logic [31:0] en_n, en_m;
        enable = en; fetch_instr = ins; rf_rdata_a = da; rf_rdata_b = db;
        #1;
        chk("R2 addr_a", {28'd0, rf_raddr_a}, {28'd0, f_a(ins)});
        chk("R3 addr_b", {28'd0, rf_raddr_b}, {28'd0, f_b(ins)});
        chk("R4 ready", {31'd0, ready}, {31'd0, m_ready});
        chk("R5 dec_instr", dec_instr, m_instr);
        chk("R9 R10 stall", {31'd0, load_use_stall}, {31'd0, m_stall});
        en_n = m_ready ? da : m_on;
        en_m = m_ready ? (m_bpc ? db + 32'd4 : db) : m_om;
        chk(m_ready ? "R6 opnd_n" : "R8 opnd_n hold", opnd_n, en_n);
        chk(m_ready ? "R7 opnd_m" : "R8 opnd_m hold", opnd_m, en_m);
        @(posedge clk);
        m_on = en_n; m_om = en_m;
        m_ready = en;
        if (en) begin
            m_stall    = m_prev_ld && (m_prev_dst == f_a(ins) || m_prev_dst == f_b(ins));
            m_prev_ld  = f_ld(ins);
            m_prev_dst = ins[15:12];
            m_instr    = ins;
            m_bpc      = (f_b(ins) == 4'd15);
        end
        @(negedge clk);
    endtask

    initial begin
        logic [3:0] pool [5];
        int unsigned seed;
        pool[0] = 4'd0; pool[1] = 4'd4; pool[2] = 4'd5; pool[3] = 4'd9; pool[4] = 4'd15;
        seed = $urandom(32'h5EED_1234);
        rst_n = 1'b0;
        enable = 1'b1;
        fetch_instr = mk(1, 4'd8, 4'd4, 4'd9);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1 ready", {31'd0, ready}, 32'd0);
        chk("R1 stall", {31'd0, load_use_stall}, 32'd0);
        chk("R1 dec_instr", dec_instr, 32'd0);
        chk("R1 opnd_n", opnd_n, 32'd0);
        chk("R1 opnd_m", opnd_m, 32'd0);
        m_ready = 0; m_instr = '0; m_stall = 0; m_prev_ld = 0; m_prev_dst = '0;
        m_bpc = 0; m_on = '0; m_om = '0;
        rst_n = 1'b1;

        // directed: load r4 then dependent move, then PC operands, then disable
        step(1, mk(1, 4'd8, 4'd4, 4'd9), 32'h11, 32'h22);
        step(1, mk(0, 4'd0, 4'd5, 4'd4), 32'h33, 32'h44);   // sets stall (R9)
        step(1, mk(0, 4'd15, 4'd14, 4'd4), 32'h55, 32'h66); // stall clears
        step(1, mk(0, 4'd4, 4'd14, 4'd15), 32'h100, 32'h200); // R6 A=15 path
        step(1, mk(2, 4'd8, 4'd15, 4'd1), 32'h300, 32'h400);  // R7 +4 on B
        step(1, mk(1, 4'd2, 4'd7, 4'd3), 32'h500, 32'hFFFF_FFFE); // R7 wrap
        step(0, mk(0, 4'd7, 4'd1, 4'd1), 32'hDEAD, 32'hBEEF); // pause edge
        step(0, mk(0, 4'd7, 4'd1, 4'd7), 32'hAAAA, 32'hBBBB); // R8 hold, R10
        step(1, mk(0, 4'd7, 4'd1, 4'd2), 32'h1, 32'h2);       // hazard vs held load
        step(1, mk(0, 4'd1, 4'd2, 4'd3), 32'h3, 32'h4);

        // random mix
        for (int n = 0; n < 400; n++) begin
            int k;
            k = $urandom_range(2, 0);
            step(($urandom_range(3, 0) != 0),
                 mk(k, pool[$urandom_range(4, 0)], pool[$urandom_range(4, 0)], pool[$urandom_range(4, 0)]),
                 $urandom(), $urandom());
        end
        done = 1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=hung expected=done");
            end
        join_any
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule